// File: doc/BRIEF.md
# Power-On Reset and Clock-Enable Sequencer

This block releases three clients from reset in a fixed order after power-up. The clients are a microcontroller, a DSP and a mixed-signal interface device. While the active-low power-up reset input is low, everything is held: all resets, all clock enables and the pin direction overrides. Once that input rises, the microcontroller gets a half-rate clock enable. Its synchronous reset logic needs running clock edges to settle, so its reset is held for a fixed number of its own clock pulses and then released.

The DSP receives full-rate clock enables from the first cycle. Its reset, and the reset of the interface device, stay asserted until the microcontroller clears a hold bit. The microcontroller can set that bit again at any time. Bidirectional pins shared with each processor are forced to input on this side while that processor is in reset.

The DSP can gate off its own clock with a sleep request. Any interrupt line turns the clock back on. That interrupt is then held away from the DSP for a programmable number of system cycles, so the DSP clock is stable before the interrupt reaches it. The block also carries an enable bit for the slow (32 kHz) clock domain, which stays off until software turns it on.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `purN` is low, `mcuRstN`, `dspRstN` and `ifcRstN` are 0; `mcuClkEn`, `dspClkEn` and `slowClkEn` are 0; `mcuPinsIn` and `dspPinsIn` are 1; `dspIrqOut` is 0 whatever `irqIn` is. `ifcRstN` follows `purN` low with no clock edge needed.
- R2: After `purN` rises, `mcuClkEn` is 1 after the first rising clock edge and then alternates every edge, so it is 1 after odd edges and 0 after even edges. `dspClkEn` is 1 from the first edge while the DSP is not asleep.
- R3: `mcuRstN` goes high at rising edge 256 after `purN` rises, which is the 128th cycle with `mcuClkEn` high. Once high, it stays high until `purN` falls.
- R4: Register writes (`regWrEn` high) are ignored while `mcuRstN` is low.
- R5: Address 0 bit 0 is the DSP hold bit, with reset value 1. `dspRstN` and `ifcRstN` equal the inverse of this bit from the edge that writes it. Writing it back to 1 re-asserts both resets.
- R6: Address 0 bit 1 drives `slowClkEn`. Its reset value is 0.
- R7: `mcuPinsIn` is 1 exactly while `mcuRstN` is 0. `dspPinsIn` is 1 exactly while `dspRstN` is 0.
- R8: A `sleepReq` pulse while the DSP is out of reset and no `irqIn` bit is set drives `dspClkEn` to 0 after that edge. While asleep, `dspIrqOut` is 0.
- R9: While asleep, any `irqIn` bit high at an edge drives `dspClkEn` back to 1 after that edge. `dspIrqOut` then stays 0 for D further cycles and follows `irqIn` after that. D is address 1 (8 bits, reset value 16); with D = 0 it follows at once.
- R10: A `sleepReq` in a cycle where any `irqIn` bit is high is ignored.
- R11: Asserting the DSP hold bit cancels sleep and any pending interrupt hold-off. `sleepReq` has no effect while the DSP is in reset.
- R12: Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| purN | input | 1 | Active-low power-up reset, asynchronous assert |
| regWrEn | input | 1 | Register write strobe from the microcontroller |
| regAddr | input | 2 | Register address (0 control, 1 wake delay) |
| regWrData | input | 8 | Register write data |
| sleepReq | input | 1 | DSP request to stop its clock |
| irqIn | input | 4 | Interrupt lines headed to the DSP |
| mcuRstN | output | 1 | Microcontroller reset, active low |
| dspRstN | output | 1 | DSP reset, active low |
| ifcRstN | output | 1 | Interface device reset, active low |
| mcuClkEn | output | 1 | Half-rate clock enable for the microcontroller |
| dspClkEn | output | 1 | Full-rate clock enable for the DSP |
| slowClkEn | output | 1 | Slow clock domain enable |
| mcuPinsIn | output | 1 | Force microcontroller shared pins to input |
| dspPinsIn | output | 1 | Force DSP shared pins to input |
| dspIrqOut | output | 4 | Interrupts delivered to the DSP after hold-off |

## Verification
Two functions can meet in one cycle. The first is a sleep request arriving in the same cycle as an interrupt. The second is a hold-bit write landing on the same edge as a sleep request or a wake event. Directed cases drive each pair together: a simultaneous request and interrupt must leave the clock running, and a hold write during sleep must clear sleep and the hold-off. A long random run then mixes sparse writes, interrupts and sleep requests. A bench-side cycle model predicts the clock enable, resets and delivered interrupts on every cycle.

// File: rtl/pwrup_rst_pkg.sv
package pwrup_rst_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_WAKE = 2'd1;

  typedef struct packed {
    logic wrDelay;
    logic loadHold;
    logic clearHold;
  } dpStrobe_t;
endpackage

// File: rtl/pwrup_rst_dp.sv
module pwrup_rst_dp
  import pwrup_rst_pkg::*;
#(
  parameter int MCU_RST_PULSES = 128,
  parameter int DATA_W         = 8,
  parameter int DELAY_RST      = 16
) (
  input  logic              clk,
  input  logic              purN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  output logic              mcuClkEn,
  output logic              mcuRun,
  output logic              alive,
  output logic              holdZero
);
  localparam int CNT_W = $clog2(MCU_RST_PULSES + 1);
  localparam logic [CNT_W-1:0] LAST_PULSE = CNT_W'(MCU_RST_PULSES - 1);

  logic              phase;
  logic              aliveQ;
  logic              mcuRunQ;
  logic [CNT_W-1:0]  pulseCnt;
  logic [DATA_W-1:0] delayReg;
  logic [DATA_W-1:0] holdCnt;

  // Half-rate enable and a marker for "first edge seen"
  always_ff @(posedge clk or negedge purN) begin
    if (!purN) begin
      phase  <= 1'b0;
      aliveQ <= 1'b0;
    end else begin
      phase  <= ~phase;
      aliveQ <= 1'b1;
    end
  end

  // Microcontroller reset counter, counted in its own clock pulses
  always_ff @(posedge clk or negedge purN) begin
    if (!purN) begin
      pulseCnt <= '0;
      mcuRunQ  <= 1'b0;
    end else if (!mcuRunQ && phase) begin
      pulseCnt <= pulseCnt + 1'b1;
      if (pulseCnt == LAST_PULSE) mcuRunQ <= 1'b1;
    end
  end

  // Wake delay register
  always_ff @(posedge clk or negedge purN) begin
    if (!purN)               delayReg <= DATA_W'(DELAY_RST);
    else if (strobe.wrDelay) delayReg <= wrData;
  end

  // Interrupt hold-off counter
  always_ff @(posedge clk or negedge purN) begin
    if (!purN)                 holdCnt <= '0;
    else if (strobe.clearHold) holdCnt <= '0;
    else if (strobe.loadHold)  holdCnt <= delayReg;
    else if (holdCnt != '0)    holdCnt <= holdCnt - 1'b1;
  end

  assign mcuClkEn = phase;
  assign mcuRun   = mcuRunQ;
  assign alive    = aliveQ;
  assign holdZero = (holdCnt == '0);

  assert_mcu_stays_run_R3: assert property (@(posedge clk) disable iff (!purN)
    mcuRunQ |=> mcuRunQ);

  assert_release_on_pulse_R3: assert property (@(posedge clk) disable iff (!purN)
    $rose(mcuRunQ) |-> $past(phase));

  assert_hold_countdown_R9: assert property (@(posedge clk) disable iff (!purN)
    (holdCnt != '0 && !strobe.loadHold && !strobe.clearHold)
      |=> (holdCnt == $past(holdCnt) - 1'b1));
endmodule

// File: rtl/pwrup_rst_ctrl.sv
module pwrup_rst_ctrl
  import pwrup_rst_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic              clk,
  input  logic              purN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [1:0]        ctrlBits,
  input  logic              sleepReq,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic              mcuRun,
  input  logic              holdZero,
  output dpStrobe_t         strobe,
  output logic              dspHold,
  output logic              slowOn,
  output logic              asleep,
  output logic              irqGate
);
  logic wrOk;
  logic ctrlWr;
  logic anyIrq;
  logic nextHold;
  logic wakeNow;
  logic sleepNow;

  assign wrOk     = regWrEn && mcuRun;
  assign ctrlWr   = wrOk && (regAddr == ADDR_CTRL);
  assign anyIrq   = |irqIn;
  assign nextHold = ctrlWr ? ctrlBits[0] : dspHold;
  assign wakeNow  = asleep && anyIrq && !nextHold;
  assign sleepNow = !asleep && sleepReq && !anyIrq && !dspHold && !nextHold;

  always_comb begin
    strobe           = '0;
    strobe.wrDelay   = wrOk && (regAddr == ADDR_WAKE);
    strobe.clearHold = nextHold;
    strobe.loadHold  = wakeNow;
  end

  always_ff @(posedge clk or negedge purN) begin
    if (!purN) begin
      dspHold <= 1'b1;
      slowOn  <= 1'b0;
    end else if (ctrlWr) begin
      dspHold <= ctrlBits[0];
      slowOn  <= ctrlBits[1];
    end
  end

  always_ff @(posedge clk or negedge purN) begin
    if (!purN)         asleep <= 1'b0;
    else if (nextHold) asleep <= 1'b0;
    else if (wakeNow)  asleep <= 1'b0;
    else if (sleepNow) asleep <= 1'b1;
  end

  assign irqGate = !dspHold && !asleep && holdZero;

  assert_wr_blocked_R4: assert property (@(posedge clk) disable iff (!purN)
    !mcuRun |=> ($stable(dspHold) && $stable(slowOn)));

  assert_hold_clears_sleep_R11: assert property (@(posedge clk) disable iff (!purN)
    dspHold |=> !asleep);

  assert_irq_blocks_sleep_R10: assert property (@(posedge clk) disable iff (!purN)
    (!asleep && anyIrq) |=> !asleep);
endmodule

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq
  import pwrup_rst_pkg::*;
#(
  parameter int MCU_RST_PULSES = 128,
  parameter int DATA_W         = 8,
  parameter int DELAY_RST      = 16,
  parameter int NUM_IRQ        = 4
) (
  input  logic               clk,
  input  logic               purN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               sleepReq,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               mcuRstN,
  output logic               dspRstN,
  output logic               ifcRstN,
  output logic               mcuClkEn,
  output logic               dspClkEn,
  output logic               slowClkEn,
  output logic               mcuPinsIn,
  output logic               dspPinsIn,
  output logic [NUM_IRQ-1:0] dspIrqOut
);
  dpStrobe_t strobe;
  logic mcuRun, alive, holdZero;
  logic dspHold, slowOn, asleep, irqGate;

  pwrup_rst_dp #(
    .MCU_RST_PULSES(MCU_RST_PULSES),
    .DATA_W        (DATA_W),
    .DELAY_RST     (DELAY_RST)
  ) u_dp (
    .clk     (clk),
    .purN    (purN),
    .strobe  (strobe),
    .wrData  (regWrData),
    .mcuClkEn(mcuClkEn),
    .mcuRun  (mcuRun),
    .alive   (alive),
    .holdZero(holdZero)
  );

  pwrup_rst_ctrl #(.NUM_IRQ(NUM_IRQ)) u_ctrl (
    .clk     (clk),
    .purN    (purN),
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .ctrlBits(regWrData[1:0]),
    .sleepReq(sleepReq),
    .irqIn   (irqIn),
    .mcuRun  (mcuRun),
    .holdZero(holdZero),
    .strobe  (strobe),
    .dspHold (dspHold),
    .slowOn  (slowOn),
    .asleep  (asleep),
    .irqGate (irqGate)
  );

  assign mcuRstN   = mcuRun;
  assign dspRstN   = ~dspHold;
  assign ifcRstN   = ~dspHold;
  assign mcuPinsIn = ~mcuRun;
  assign dspPinsIn = dspHold;
  assign dspClkEn  = alive && !asleep;
  assign slowClkEn = slowOn;
  assign dspIrqOut = irqIn & {NUM_IRQ{irqGate}};

  assert_irq_masked_asleep_R8: assert property (@(posedge clk) disable iff (!purN)
    !dspClkEn |-> (dspIrqOut == '0));

  assert_pins_follow_reset_R7: assert property (@(posedge clk) disable iff (!purN)
    (mcuPinsIn == !mcuRstN) && (dspPinsIn == !dspRstN));
endmodule

// File: tb/test_pwrup_rst_seq.sv
module test_pwrup_rst_seq;
  logic       clk = 1'b0;
  logic       purN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic       sleepReq = 1'b0;
  logic [3:0] irqIn = '0;
  logic mcuRstN, dspRstN, ifcRstN, mcuClkEn, dspClkEn, slowClkEn, mcuPinsIn, dspPinsIn;
  logic [3:0] dspIrqOut;

  int nChk = 0;
  int nBad = 0;

  // bench-side model state
  logic       mHold, mSleep, mSlow;
  logic [7:0] mCnt, mDelay;

  always #5 clk = ~clk;

  pwrup_rst_seq i_pwrup_rst_seq (
    .clk(clk), .purN(purN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .sleepReq(sleepReq), .irqIn(irqIn), .mcuRstN(mcuRstN), .dspRstN(dspRstN),
    .ifcRstN(ifcRstN), .mcuClkEn(mcuClkEn), .dspClkEn(dspClkEn), .slowClkEn(slowClkEn),
    .mcuPinsIn(mcuPinsIn), .dspPinsIn(dspPinsIn), .dspIrqOut(dspIrqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  function automatic logic [3:0] expIrq(input logic [3:0] irq);
    return (!mHold && !mSleep && mCnt == 0) ? irq : 4'h0;
  endfunction

  task automatic modelStep();
    logic nh;
    logic wrOn;
    wrOn = regWrEn;
    nh = (wrOn && regAddr == 2'd0) ? regWrData[0] : mHold;
    if (wrOn && regAddr == 2'd0) mSlow = regWrData[1];
    if (nh) begin
      mSleep = 1'b0; mCnt = 8'd0;
    end else if (mSleep && |irqIn) begin
      mSleep = 1'b0; mCnt = mDelay;
    end else begin
      if (!mSleep && !mHold && sleepReq && !(|irqIn)) mSleep = 1'b1;
      if (mCnt != 0) mCnt = mCnt - 1'b1;
    end
    mHold = nh;
    if (wrOn && regAddr == 2'd1) mDelay = regWrData;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    irqIn = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 mcuRstN", mcuRstN, 0);
    chk("R1 dspRstN", dspRstN, 0);
    chk("R1 ifcRstN", ifcRstN, 0);
    chk("R1 mcuClkEn", mcuClkEn, 0);
    chk("R1 dspClkEn", dspClkEn, 0);
    chk("R1 slowClkEn", slowClkEn, 0);
    chk("R1 pins", {mcuPinsIn, dspPinsIn}, 2'b11);
    chk("R1 irq", dspIrqOut, 0);
    irqIn = 4'h0;
    purN = 1'b1;
    for (int k = 1; k <= 256; k++) begin
      if (k == 10) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = 8'h02; end
      else if (k == 11) begin regWrEn = 1'b1; regAddr = 2'd1; regWrData = 8'h05; end
      else regWrEn = 1'b0;
      tick();
      chk("R2 mcuClkEn", mcuClkEn, (k % 2 == 1) ? 1 : 0);
      if (k == 1) chk("R2 dspClkEn", dspClkEn, 1);
      if (k == 255) begin
        chk("R3 mcuRstN low", mcuRstN, 0);
        chk("R7 mcuPinsIn", mcuPinsIn, 1);
      end
      if (k == 256) begin
        chk("R3 mcuRstN high", mcuRstN, 1);
        chk("R7 mcuPinsIn", mcuPinsIn, 0);
      end
    end
    regWrEn = 1'b0;
    chk("R4 dspRstN held", dspRstN, 0);
    chk("R4 slow unchanged", slowClkEn, 0);
    chk("R5 ifcRstN held", ifcRstN, 0);
    chk("R7 dspPinsIn", dspPinsIn, 1);

    wr(2'd0, 8'h02);
    chk("R5 dspRstN", dspRstN, 1);
    chk("R5 ifcRstN", ifcRstN, 1);
    chk("R6 slowClkEn", slowClkEn, 1);
    chk("R7 dspPinsIn", dspPinsIn, 0);
    tick(); tick();
    chk("R3 stays", mcuRstN, 1);

    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    chk("R12 dspRstN", dspRstN, 1);
    chk("R12 slowClkEn", slowClkEn, 1);

    // R8 sleep, R9 wake with default delay 16 (R12: untouched by addr 2/3, R4: untouched)
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    chk("R8 clock off", dspClkEn, 0);
    irqIn = 4'b0100;
    #1 chk("R8 irq masked", dspIrqOut, 0);
    tick();
    chk("R9 clock on", dspClkEn, 1);
    for (int j = 0; j < 16; j++) begin
      chk("R9 hold-off", dspIrqOut, 0);
      tick();
    end
    chk("R9 delivered", dspIrqOut, 4'b0100);

    // R10 request together with interrupt
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    chk("R10 stays awake", dspClkEn, 1);
    irqIn = 4'h0;

    // R11 hold during sleep
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    chk("R11 asleep", dspClkEn, 0);
    wr(2'd0, 8'h03);
    chk("R11 dspRstN", dspRstN, 0);
    chk("R5 reassert ifc", ifcRstN, 0);
    chk("R11 clock on", dspClkEn, 1);
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    chk("R11 req ignored", dspClkEn, 1);
    wr(2'd0, 8'h02);

    // R9 boundary: zero delay
    wr(2'd1, 8'h00);
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    irqIn = 4'b1001; tick();
    chk("R9 zero delay clk", dspClkEn, 1);
    chk("R9 zero delay irq", dspIrqOut, 4'b1001);
    irqIn = 4'h0;
    // R9 delay 3
    wr(2'd1, 8'h03);
    sleepReq = 1'b1; tick(); sleepReq = 1'b0;
    irqIn = 4'b0010; tick();
    for (int j = 0; j < 3; j++) begin
      chk("R9 delay3 hold", dspIrqOut, 0);
      tick();
    end
    chk("R9 delay3 out", dspIrqOut, 4'b0010);
    irqIn = 4'h0;
    tick(); tick(); tick();

    // random phase
    mHold = 1'b0; mSleep = 1'b0; mSlow = 1'b1; mCnt = 8'd0; mDelay = 8'd3;
    for (int c = 0; c < 4000; c++) begin
      regWrEn = ($urandom % 16) == 0;
      regAddr = 2'($urandom % 4);
      regWrData = (regAddr == 2'd1) ? 8'($urandom % 6)
                : {6'd0, 1'($urandom), 1'(($urandom % 4) == 0)};
      sleepReq = ($urandom % 5) == 0;
      irqIn = (($urandom % 7) == 0) ? 4'($urandom) : 4'h0;
      #1;
      chk("R8 random clk", dspClkEn, !mSleep);
      chk("R9 random irq", dspIrqOut, expIrq(irqIn));
      chk("R5 random rst", dspRstN, !mHold);
      chk("R6 random slow", slowClkEn, mSlow);
      modelStep();
      tick();
    end
    regWrEn = 1'b0; sleepReq = 1'b0; irqIn = 4'h0;

    // R1 asynchronous re-entry into reset
    #2 purN = 1'b0;
    #1 chk("R1 ifc async", ifcRstN, 0);
    chk("R1 mcu async", mcuRstN, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule